// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block is the priority core of an eight-level interrupt controller. Each cycle it receives the request, mask and in-service vectors, a lowest-priority pointer and a special-mask flag. When a re-evaluate strobe arrives, it picks one winning level and raises a registered pending flag. The pending flag and the level stay fixed until an acknowledge arrives. Priority is circular. The top level is the one just after the pointer, and the ranking wraps from the last level back to level 0.

The block also does the search for a non-specific end-of-interrupt. On a strobe it returns a one-hot mask of the single in-service bit to clear, together with the pointer value to use next. With rotation selected, that pointer advances by one. The surrounding controller owns the registers and applies these results. It also runs the processor acknowledge cycle.

A small state machine has two states. In `IDLE` nothing is pending. The transition *eval-hit* (a re-evaluate strobe with an eligible level and no acknowledge) moves it to `PENDING`. The transition *ack* returns from `PENDING` to `IDLE`. An acknowledge that arrives together with a strobe also takes the *ack* path. Every other input combination stays in the current state.

Top module: `prio_resolver`

## Requirements
- R1: After reset `int_o` is 0 and `eoi_done_o` is 0.
- R2: The top level is `ptr_i`+1 modulo LEVELS. Among eligible levels, the first one met when scanning upward from the top level wins, and the scan wraps from LEVELS-1 to 0.
- R3: The candidate levels are `req_i & ~mask_i`. When no candidate exists, a strobe leaves `int_o` at 0.
- R4: In normal mode (`special_i`=0) with some in-service bit set, only candidates that come strictly before the first in-service level in the scan order from the top can win.
- R5: In normal mode, if the top level itself is in service, no level is signalled.
- R6: In special-mask mode (`special_i`=1), any candidate whose in-service bit is clear may win, including candidates ranked below in-service levels.
- R7: `int_o` and `level_o` change on the clock edge after a strobe. Without a strobe, changes to the input vectors have no effect on them.
- R8: While `int_o` is 1, further strobes are ignored and `level_o` is held. An `ack_i` clears `int_o` on the next edge.
- R9: One edge after `eoi_i`, `eoi_done_o` pulses for one cycle. At the same edge `eoi_clear_o` holds a one-hot mask of the first set in-service bit found scanning from the top level, or all zeros if no bit is set.
- R10: With `eoi_i`, `eoi_ptr_o` returns `ptr_i`+1 modulo LEVELS when `rotate_i` is 1, and `ptr_i` unchanged when `rotate_i` is 0.
- R11: When `ack_i` and `eval_i` are high in the same cycle, the acknowledge wins: `int_o` is 0 afterwards and no new evaluation takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | LEVELS | Request vector |
| mask_i | input | LEVELS | Mask vector, 1 blocks a level |
| insvc_i | input | LEVELS | In-service vector |
| ptr_i | input | PTR_W | Lowest-priority pointer |
| special_i | input | 1 | Special-mask mode select |
| eval_i | input | 1 | Re-evaluate strobe |
| ack_i | input | 1 | Acknowledge, clears pending |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| rotate_i | input | 1 | Rotate pointer on end-of-interrupt |
| int_o | output | 1 | Interrupt pending |
| level_o | output | PTR_W | Winning level |
| eoi_done_o | output | 1 | End-of-interrupt result valid |
| eoi_clear_o | output | LEVELS | One-hot in-service bit to clear |
| eoi_ptr_o | output | PTR_W | Pointer value after end-of-interrupt |

## Verification
The bench builds the block with LEVELS set to 8, so PTR_W is 3. This gives every pointer position a real wrap point, and lets a request set straddle the boundary from level 7 to level 0. With eight levels the bench can place in-service bits above, below and exactly at the top level, so the normal-mode window can be tested at its full width, at a partial width and at zero width. A bench-side scan model predicts each winner and each end-of-interrupt result one edge ahead.

// File: rtl/prio_pkg.sv
package prio_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } res_state_t;
endpackage

// File: rtl/prio_first_set.sv
// Finds the first set bit of vec_i when scanning upward from top_i, wrapping.
module prio_first_set #(
    parameter int LEVELS = 8,
    localparam int PTR_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [LEVELS-1:0] vec_i,
    input  logic [PTR_W-1:0]  top_i,
    output logic              found_o,
    output logic [PTR_W-1:0]  idx_o
);
    logic [LEVELS-1:0] rot;
    int                first_k;
    int                sum;

    always_comb begin
        for (int i = 0; i < LEVELS; i++) begin
            sum    = i + int'(top_i);
            if (sum >= LEVELS) sum = sum - LEVELS;
            rot[i] = vec_i[sum];
        end
        first_k = 0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (rot[i]) first_k = i;
        end
        sum = first_k + int'(top_i);
        if (sum >= LEVELS) sum = sum - LEVELS;
        idx_o   = PTR_W'(sum);
        found_o = |vec_i;
    end
endmodule

// File: rtl/prio_gate.sv
// Produces the set of levels allowed to win under normal or special-mask rules.
module prio_gate #(
    parameter int LEVELS = 8,
    localparam int PTR_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [LEVELS-1:0] cand_i,
    input  logic [LEVELS-1:0] insvc_i,
    input  logic [PTR_W-1:0]  top_i,
    input  logic              special_i,
    output logic [LEVELS-1:0] elig_o
);
    logic             svc_any;
    logic [PTR_W-1:0] svc_idx;
    int               svc_dist;
    int               bit_dist;

    prio_first_set #(.LEVELS(LEVELS)) u_svc_scan (
        .vec_i   (insvc_i),
        .top_i   (top_i),
        .found_o (svc_any),
        .idx_o   (svc_idx)
    );

    always_comb begin
        svc_dist = int'(svc_idx) - int'(top_i);
        if (svc_dist < 0) svc_dist = svc_dist + LEVELS;
        for (int i = 0; i < LEVELS; i++) begin
            bit_dist = i - int'(top_i);
            if (bit_dist < 0) bit_dist = bit_dist + LEVELS;
            if (special_i)
                elig_o[i] = cand_i[i] & ~insvc_i[i];
            else
                elig_o[i] = cand_i[i] & (!svc_any || (bit_dist < svc_dist));
        end
    end

    // R6
    always_comb begin
        special_skip_chk: assert (!special_i || ((elig_o & insvc_i) == '0));
    end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
    parameter int LEVELS = 8,
    localparam int PTR_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] req_i,
    input  logic [LEVELS-1:0] mask_i,
    input  logic [LEVELS-1:0] insvc_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic              special_i,
    input  logic              eval_i,
    input  logic              ack_i,
    input  logic              eoi_i,
    input  logic              rotate_i,
    output logic              int_o,
    output logic [PTR_W-1:0]  level_o,
    output logic              eoi_done_o,
    output logic [LEVELS-1:0] eoi_clear_o,
    output logic [PTR_W-1:0]  eoi_ptr_o
);
    import prio_pkg::*;

    res_state_t        state_q, state_d;
    logic [PTR_W-1:0]  top_lvl;
    logic [PTR_W-1:0]  ptr_inc;
    logic [LEVELS-1:0] cand;
    logic [LEVELS-1:0] elig;
    logic              win_found;
    logic [PTR_W-1:0]  win_idx;
    logic              eoi_found;
    logic [PTR_W-1:0]  eoi_idx;
    logic              take_win;

    assign ptr_inc = (int'(ptr_i) == LEVELS - 1) ? '0 : ptr_i + 1'b1;
    assign top_lvl = ptr_inc;
    assign cand    = req_i & ~mask_i;

    prio_gate #(.LEVELS(LEVELS)) u_gate (
        .cand_i    (cand),
        .insvc_i   (insvc_i),
        .top_i     (top_lvl),
        .special_i (special_i),
        .elig_o    (elig)
    );

    prio_first_set #(.LEVELS(LEVELS)) u_win_scan (
        .vec_i   (elig),
        .top_i   (top_lvl),
        .found_o (win_found),
        .idx_o   (win_idx)
    );

    prio_first_set #(.LEVELS(LEVELS)) u_eoi_scan (
        .vec_i   (insvc_i),
        .top_i   (top_lvl),
        .found_o (eoi_found),
        .idx_o   (eoi_idx)
    );

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        take_win = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (eval_i && !ack_i && win_found) begin
                    state_d  = ST_PENDING;
                    take_win = 1'b1;
                end
            end
            ST_PENDING: begin
                if (ack_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o     <= '0;
            eoi_done_o  <= 1'b0;
            eoi_clear_o <= '0;
            eoi_ptr_o   <= '0;
        end else begin
            if (take_win) level_o <= win_idx;
            eoi_done_o  <= eoi_i;
            eoi_clear_o <= '0;
            if (eoi_i) begin
                if (eoi_found) eoi_clear_o <= LEVELS'(1) << eoi_idx;
                eoi_ptr_o <= rotate_i ? ptr_inc : ptr_i;
            end
        end
    end

    assign int_o = (state_q == ST_PENDING);

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && !ack_i) |=> (int_o && $stable(level_o)));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !int_o);

    // R3
    no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_o && eval_i && (cand == '0)) |=> !int_o);

    // R4
    winner_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_o) |->
            (((($past(req_i) & ~$past(mask_i)) >> level_o) & LEVELS'(1)) == LEVELS'(1)) &&
            ((($past(insvc_i) >> level_o) & LEVELS'(1)) == '0));

    // R9
    eoi_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eoi_clear_o));

    // R9
    eoi_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_done_o |-> ((eoi_clear_o & ~$past(insvc_i)) == '0));

    // R7
    int_needs_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_o) |-> $past(eval_i));
endmodule

// File: tb/prio_resolver_test.sv
`timescale 1ns/1ps
module prio_resolver_test;
    localparam int LEVELS = 8;
    localparam int PTR_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LEVELS-1:0] req_i = '0, mask_i = '0, insvc_i = '0;
    logic [PTR_W-1:0]  ptr_i = 3'd7;
    logic              special_i = 1'b0, eval_i = 1'b0, ack_i = 1'b0;
    logic              eoi_i = 1'b0, rotate_i = 1'b0;
    logic              int_o;
    logic [PTR_W-1:0]  level_o;
    logic              eoi_done_o;
    logic [LEVELS-1:0] eoi_clear_o;
    logic [PTR_W-1:0]  eoi_ptr_o;

    prio_resolver #(.LEVELS(LEVELS)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
        .insvc_i(insvc_i), .ptr_i(ptr_i), .special_i(special_i),
        .eval_i(eval_i), .ack_i(ack_i), .eoi_i(eoi_i), .rotate_i(rotate_i),
        .int_o(int_o), .level_o(level_o), .eoi_done_o(eoi_done_o),
        .eoi_clear_o(eoi_clear_o), .eoi_ptr_o(eoi_ptr_o)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          cyc;
        bit          kind;   // 0: pending/level, 1: end-of-interrupt
        logic [11:0] exp;
        logic [11:0] msk;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    bit    m_int = 1'b0;
    logic [2:0] m_lvl = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares queued expectations in their due cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc == cyc) begin
            item_t it;
            logic [11:0] obs;
            it  = q.pop_front();
            obs = it.kind ? {eoi_done_o, eoi_clear_o, eoi_ptr_o} : {8'h00, int_o, level_o};
            checks++;
            if ((obs & it.msk) !== (it.exp & it.msk)) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, obs & it.msk, it.exp & it.msk);
            end
        end
    end

    function automatic logic [2:0] top_of(input logic [2:0] p);
        return p + 3'd1;
    endfunction

    // Reference walk: upward from top, stop at in-service (normal), skip it (special)
    function automatic logic [3:0] ref_win(input logic [7:0] rq, input logic [7:0] mk,
                                           input logic [7:0] sv, input logic [2:0] p,
                                           input bit sp);
        logic [2:0] l;
        l = top_of(p);
        for (int k = 0; k < 8; k++) begin
            if (sv[l] && !sp) return 4'b0000;
            if (rq[l] && !mk[l] && !sv[l]) return {1'b1, l};
            l = l + 3'd1;
        end
        return 4'b0000;
    endfunction

    function automatic logic [7:0] ref_eoi(input logic [7:0] sv, input logic [2:0] p);
        logic [2:0] l;
        l = top_of(p);
        for (int k = 0; k < 8; k++) begin
            if (sv[l]) return 8'b1 << l;
            l = l + 3'd1;
        end
        return 8'h00;
    endfunction

    task automatic push_state(input string tag);
        item_t it;
        it.cyc = cyc + 1; it.kind = 1'b0;
        it.exp = {8'h00, m_int, m_lvl};
        it.msk = m_int ? 12'h00F : 12'h008;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic t_eval(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] sv,
                          input logic [2:0] p, input bit sp, input string tag);
        logic [3:0] r;
        req_i = rq; mask_i = mk; insvc_i = sv; ptr_i = p; special_i = sp; eval_i = 1'b1;
        if (!m_int) begin
            r = ref_win(rq, mk, sv, p, sp);
            if (r[3]) begin m_int = 1'b1; m_lvl = r[2:0]; end
        end
        push_state(tag);
        @(negedge clk);
        eval_i = 1'b0;
    endtask

    task automatic t_ack(input bit with_eval, input string tag);
        ack_i = 1'b1; eval_i = with_eval;
        m_int = 1'b0;
        push_state(tag);
        @(negedge clk);
        ack_i = 1'b0; eval_i = 1'b0;
    endtask

    task automatic t_idle(input logic [7:0] rq, input string tag);
        req_i = rq; mask_i = 8'h00; insvc_i = 8'h00;
        push_state(tag);
        @(negedge clk);
    endtask

    task automatic t_eoi(input logic [7:0] sv, input logic [2:0] p, input bit rot,
                         input string tag);
        item_t it;
        insvc_i = sv; ptr_i = p; rotate_i = rot; eoi_i = 1'b1;
        it.cyc = cyc + 1; it.kind = 1'b1;
        it.exp = {1'b1, ref_eoi(sv, p), rot ? p + 3'd1 : p};
        it.msk = 12'hFFF; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        eoi_i = 1'b0;
        it.cyc = cyc + 1;
        it.exp = 12'h000; it.msk = 12'h800; it.tag = {tag, "_pulse"};
        q.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (int_o !== 1'b0 || eoi_done_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 actual=%b%b expected=00", int_o, eoi_done_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: pointer 7, top 0; bits 3 and 5 -> 3
        t_eval(8'h28, 8'h00, 8'h00, 3'd7, 1'b0, "R2_top0");
        t_ack(1'b0, "R8_ack");
        // R2: top 3 picks 3 over 0
        t_eval(8'h09, 8'h00, 8'h00, 3'd2, 1'b0, "R2_top3");
        t_ack(1'b0, "R8_ack");
        // R2: top 4 wraps to 0
        t_eval(8'h09, 8'h00, 8'h00, 3'd3, 1'b0, "R2_wrap");
        t_ack(1'b0, "R8_ack");
        // R3: masked candidate skipped, then none left
        t_eval(8'h09, 8'h08, 8'h00, 3'd7, 1'b0, "R3_mask");
        t_ack(1'b0, "R8_ack");
        t_eval(8'h09, 8'h09, 8'h00, 3'd7, 1'b0, "R3_none");
        // R4: in-service 4 blocks 5 and 6; lets 2 through
        t_eval(8'h60, 8'h00, 8'h10, 3'd7, 1'b0, "R4_blocked");
        t_eval(8'h64, 8'h00, 8'h10, 3'd7, 1'b0, "R4_above");
        t_ack(1'b0, "R8_ack");
        // R5: top level in service
        t_eval(8'hFF, 8'h00, 8'h10, 3'd3, 1'b0, "R5_top_svc");
        // R6: special mask lets 5 through past in-service 4
        t_eval(8'h30, 8'h00, 8'h10, 3'd7, 1'b1, "R6_special");
        t_ack(1'b0, "R8_ack");
        // R7: no strobe, inputs change, nothing happens
        t_idle(8'hFF, "R7_no_eval");
        t_idle(8'h01, "R7_no_eval2");
        // R8: held while pending
        t_eval(8'h02, 8'h00, 8'h00, 3'd7, 1'b0, "R8_first");
        t_eval(8'h01, 8'h00, 8'h00, 3'd7, 1'b0, "R8_hold");
        t_idle(8'h00, "R8_hold2");
        t_ack(1'b0, "R8_ack");
        // R11: ack with strobe
        t_eval(8'h80, 8'h00, 8'h00, 3'd7, 1'b0, "R11_setup");
        req_i = 8'h01; mask_i = 8'h00; insvc_i = 8'h00;
        t_ack(1'b1, "R11_ack_wins");
        t_idle(8'h00, "R11_stays_low");
        // R9 / R10: end-of-interrupt search
        t_eoi(8'h28, 3'd7, 1'b0, "R9_first");
        t_eoi(8'h28, 3'd4, 1'b1, "R10_rotate");
        t_eoi(8'h00, 3'd2, 1'b0, "R9_empty");
        t_eoi(8'h81, 3'd7, 1'b1, "R10_wrap");
        t_eoi(8'hC0, 3'd6, 1'b0, "R9_top7");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule